// File: doc/BRIEF.md
# Nibble Accumulator Execute Unit

This block is the execute stage of a small 4-bit controller core. It covers arithmetic, constant-load and conditional-test instructions. Each cycle it takes an 8-bit opcode, the accumulator value, the RAM operand and the carry flag, and returns the next accumulator value and the next carry value. It also returns a strobe that says the accumulator must be written back, and a skip request that tells the sequencer to drop the following instruction.

Most add forms do not leave a flag for a later branch. They raise a skip directly when the sum carries out of four bits. The plain add never touches carry, and the carry test skips when carry is clear. A `hit_o` flag marks the opcodes the unit implements. Any other opcode passes the accumulator and carry through unchanged and raises nothing.

The skip request is combinational, valid in the opcode's own cycle. A copy of it is registered once for sequencers that sample a cycle later.

Top module: `nib_alu_exec`

## Requirements
- R1: Opcode 0x08 writes the low 4 bits of A+M to the accumulator, sets `wr_acc_o`, keeps carry unchanged and never raises a skip.
- R2: Opcode 0x09 writes the low 4 bits of A+M+C to the accumulator, drives `cy_o` with bit 4 of that 5-bit sum, and raises a skip exactly when that bit is 1.
- R3: Opcodes 0x30 to 0x3F add the constant k held in opcode bits [3:0] to A, write the low 4 bits, keep carry unchanged, and raise a skip exactly when A+k exceeds 15.
- R4: Opcode 0x3A adds 10 under the R3 rule: it skips when A is 6 or more and leaves carry unchanged.
- R5: Opcodes 0x20 to 0x2F load opcode bits [3:0] into the accumulator, set `wr_acc_o`, keep carry unchanged and raise no skip.
- R6: Opcode 0x51 raises a skip exactly when C is 0. It writes nothing and leaves carry unchanged.
- R7: Opcode 0x52 raises a skip exactly when A equals M, and writes nothing.
- R8: Opcode 0x53 raises a skip exactly when A is 0, and writes nothing.
- R9: Every opcode not listed in R1 to R8 gives `hit_o`=0, `wr_acc_o`=0, `skip_o`=0, `acc_o`=A and `cy_o`=C. Every listed opcode gives `hit_o`=1.
- R10: `skip_q_o` equals the value `skip_o` had in the previous cycle, and is 0 while reset is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 8 | Opcode being executed |
| acc_i | input | 4 | Current accumulator |
| mem_i | input | 4 | RAM operand |
| cy_i | input | 1 | Current carry flag |
| acc_o | output | 4 | Next accumulator value |
| cy_o | output | 1 | Next carry value |
| wr_acc_o | output | 1 | Accumulator write-back strobe |
| skip_o | output | 1 | Skip request, same cycle |
| skip_q_o | output | 1 | Skip request, registered once |
| hit_o | output | 1 | Opcode is implemented here |

## Verification
Every opcode is run against all 512 combinations of A, M and C, so every carry boundary of each add constant is crossed. That includes 0x30, which can never skip, and 0x3A, which skips from A=6 upward. A unit that let the plain add or the add-immediate forms write carry fails on cases that carry out while C was the other value. A carry test with the inverted sense, or an add-with-carry that ignored the incoming carry, fails on the 15-versus-16 edges such as A=9, M=6, C=1. Opcodes near implemented ones (0x07, 0x0A, 0x50, 0x54) catch decode that is too loose, because they would show a write or a skip. The registered skip is checked for its one-cycle lag and for being held at 0 during a reset applied while a skipping opcode is on the input.

// File: rtl/nib_pkg.sv
package nib_pkg;
  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_ADD,
    CLS_ADC,
    CLS_ADDI,
    CLS_LDI,
    CLS_TCLR,
    CLS_TEQ,
    CLS_TZ
  } nib_cls_e;

  localparam logic [7:0] OPC_ADD    = 8'h08;
  localparam logic [7:0] OPC_ADC    = 8'h09;
  localparam logic [3:0] OPG_LDI    = 4'h2;
  localparam logic [3:0] OPG_ADDI   = 4'h3;
  localparam logic [7:0] OPC_TCLR   = 8'h51;
  localparam logic [7:0] OPC_TEQ    = 8'h52;
  localparam logic [7:0] OPC_TZ     = 8'h53;
endpackage

// File: rtl/nib_decode.sv
module nib_decode
  import nib_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic [7:0]    op_i,
  output nib_cls_e      cls_o,
  output logic [DW-1:0] imm_o
);
  localparam int IW = 4;

  assign imm_o = DW'(op_i[IW-1:0]);

  always_comb begin
    cls_o = CLS_NONE;
    if (op_i == OPC_ADD)        cls_o = CLS_ADD;
    else if (op_i == OPC_ADC)   cls_o = CLS_ADC;
    else if (op_i == OPC_TCLR)  cls_o = CLS_TCLR;
    else if (op_i == OPC_TEQ)   cls_o = CLS_TEQ;
    else if (op_i == OPC_TZ)    cls_o = CLS_TZ;
    else if (op_i[7:4] == OPG_LDI)  cls_o = CLS_LDI;
    else if (op_i[7:4] == OPG_ADDI) cls_o = CLS_ADDI;
  end
endmodule

// File: rtl/nib_adder.sv
module nib_adder #(
  parameter int DW = 4
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          cin_i,
  output logic [DW-1:0] sum_o,
  output logic          cout_o
);
  localparam int SW = DW + 1;
  logic [SW-1:0] wide;

  assign wide   = SW'(a_i) + SW'(b_i) + SW'(cin_i);
  assign sum_o  = wide[DW-1:0];
  assign cout_o = wide[DW];
endmodule

// File: rtl/nib_test.sv
module nib_test
  import nib_pkg::*;
#(
  parameter int DW = 4
) (
  input  nib_cls_e      cls_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] mem_i,
  input  logic          cy_i,
  output logic          hit_o
);
  always_comb begin
    unique case (cls_i)
      CLS_TCLR: hit_o = ~cy_i;  // skip on carry clear
      CLS_TEQ:  hit_o = (acc_i == mem_i);
      CLS_TZ:   hit_o = (acc_i == '0);
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/nib_alu_exec.sv
module nib_alu_exec
  import nib_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    op_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] mem_i,
  input  logic          cy_i,
  output logic [DW-1:0] acc_o,
  output logic          cy_o,
  output logic          wr_acc_o,
  output logic          skip_o,
  output logic          skip_q_o,
  output logic          hit_o
);
  nib_cls_e      cls;
  logic [DW-1:0] imm, add_b, sum;
  logic          cin, cout, test_skip;

  nib_decode #(.DW(DW)) u_dec (
    .op_i  (op_i),
    .cls_o (cls),
    .imm_o (imm)
  );

  assign add_b = (cls == CLS_ADDI) ? imm : mem_i;
  assign cin   = (cls == CLS_ADC) ? cy_i : 1'b0;

  nib_adder #(.DW(DW)) u_add (
    .a_i    (acc_i),
    .b_i    (add_b),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout)
  );

  nib_test #(.DW(DW)) u_tst (
    .cls_i (cls),
    .acc_i (acc_i),
    .mem_i (mem_i),
    .cy_i  (cy_i),
    .hit_o (test_skip)
  );

  always_comb begin
    acc_o    = acc_i;
    cy_o     = cy_i;
    wr_acc_o = 1'b0;
    skip_o   = 1'b0;
    unique case (cls)
      CLS_ADD: begin
        acc_o    = sum;
        wr_acc_o = 1'b1;
      end
      CLS_ADC: begin
        acc_o    = sum;
        cy_o     = cout;
        wr_acc_o = 1'b1;
        skip_o   = cout;
      end
      CLS_ADDI: begin
        acc_o    = sum;
        wr_acc_o = 1'b1;
        skip_o   = cout;
      end
      CLS_LDI: begin
        acc_o    = imm;
        wr_acc_o = 1'b1;
      end
      CLS_TCLR, CLS_TEQ, CLS_TZ: skip_o = test_skip;
      default: ;
    endcase
  end

  assign hit_o = (cls != CLS_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) skip_q_o <= 1'b0;
    else         skip_q_o <= skip_o;
  end
endmodule

// File: rtl/nib_alu_exec_chk.sv
module nib_alu_exec_chk #(
  parameter int DW = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [7:0]    op_i,
  input logic [DW-1:0] acc_i,
  input logic [DW-1:0] mem_i,
  input logic          cy_i,
  input logic [DW-1:0] acc_o,
  input logic          cy_o,
  input logic          wr_acc_o,
  input logic          skip_o,
  input logic          skip_q_o,
  input logic          hit_o
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_ADD_KEEPS_CY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 8'h08) |-> (cy_o == cy_i && !skip_o && wr_acc_o)) else $error("AST_ADD_KEEPS_CY");  // R1
  AST_ADC_SKIP_IS_CY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 8'h09) |-> ({cy_o, acc_o} == ({1'b0, acc_i} + {1'b0, mem_i} + (DW+1)'(cy_i)) && skip_o == cy_o)) else $error("AST_ADC_SKIP_IS_CY");  // R2
  AST_ADDI_KEEPS_CY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[7:4] == 4'h3) |-> (cy_o == cy_i && skip_o == ((DW+1)'(acc_i) + (DW+1)'(op_i[3:0]) > (DW+1)'(15)))) else $error("AST_ADDI_KEEPS_CY");  // R3
  AST_ADD10_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 8'h3A) |-> (skip_o == (acc_i >= DW'(6)))) else $error("AST_ADD10_SKIP");  // R4
  AST_LDI_NO_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[7:4] == 4'h2) |-> (!skip_o && cy_o == cy_i && acc_o == DW'(op_i[3:0]))) else $error("AST_LDI_NO_SKIP");  // R5
  AST_TCLR_SENSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 8'h51) |-> (skip_o == !cy_i && !wr_acc_o)) else $error("AST_TCLR_SENSE");  // R6
  AST_TEQ_SENSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 8'h52) |-> (skip_o == (acc_i == mem_i) && !wr_acc_o)) else $error("AST_TEQ_SENSE");  // R7
  AST_TZ_SENSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 8'h53) |-> (skip_o == (acc_i == '0) && !wr_acc_o)) else $error("AST_TZ_SENSE");  // R8
  AST_MISS_INERT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (!skip_o && !wr_acc_o && acc_o == acc_i && cy_o == cy_i)) else $error("AST_MISS_INERT");  // R9
  AST_SKIP_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (skip_q_o == $past(skip_o))) else $error("AST_SKIP_LAG");  // R10
endmodule

bind nib_alu_exec nib_alu_exec_chk #(.DW(DW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .op_i     (op_i),
  .acc_i    (acc_i),
  .mem_i    (mem_i),
  .cy_i     (cy_i),
  .acc_o    (acc_o),
  .cy_o     (cy_o),
  .wr_acc_o (wr_acc_o),
  .skip_o   (skip_o),
  .skip_q_o (skip_q_o),
  .hit_o    (hit_o)
);

// File: tb/nib_alu_exec_bench.sv
module nib_alu_exec_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] op_i = 8'h00;
  logic [3:0] acc_i = '0, mem_i = '0;
  logic       cy_i = 1'b0;
  logic [3:0] acc_o;
  logic       cy_o, wr_acc_o, skip_o, skip_q_o, hit_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  nib_alu_exec u_nib_alu_exec (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .acc_i(acc_i), .mem_i(mem_i),
    .cy_i(cy_i), .acc_o(acc_o), .cy_o(cy_o), .wr_acc_o(wr_acc_o),
    .skip_o(skip_o), .skip_q_o(skip_q_o), .hit_o(hit_o)
  );

  // {op, a, m, c, exp_a, exp_c, exp_skip}
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {8'h08, 4'h9, 4'h8, 1'b1, 4'h1, 1'b1, 1'b0},  // R1 carry out kept off C
    {8'h09, 4'h9, 4'h6, 1'b1, 4'h0, 1'b1, 1'b1},  // R2 16
    {8'h09, 4'h7, 4'h7, 1'b1, 4'hF, 1'b0, 1'b0},  // R2 15
    {8'h09, 4'h8, 4'h8, 1'b0, 4'h0, 1'b1, 1'b1},  // R2
    {8'h3A, 4'h6, 4'h0, 1'b0, 4'h0, 1'b0, 1'b1},  // R4
    {8'h3A, 4'h5, 4'h0, 1'b1, 4'hF, 1'b1, 1'b0},  // R4
    {8'h31, 4'hF, 4'h0, 1'b0, 4'h0, 1'b0, 1'b1},  // R3
    {8'h2C, 4'h3, 4'h1, 1'b1, 4'hC, 1'b1, 1'b0},  // R5
    {8'h51, 4'h2, 4'h2, 1'b0, 4'h2, 1'b0, 1'b1},  // R6
    {8'h51, 4'h2, 4'h2, 1'b1, 4'h2, 1'b1, 1'b0},  // R6
    {8'h52, 4'h5, 4'h5, 1'b1, 4'h5, 1'b1, 1'b1},  // R7
    {8'h53, 4'h0, 4'h4, 1'b0, 4'h0, 1'b0, 1'b1}   // R8
  };

  // independent model: {hit, wr, a, c, skip}
  function automatic logic [7:0] model(input logic [7:0] op, input logic [3:0] a,
                                       input logic [3:0] m, input logic c);
    int s;
    logic h = 1, w = 0, k = 0, nc = c;
    logic [3:0] na = a;
    if (op == 8'h08) begin s = a + m; na = s[3:0]; w = 1; end
    else if (op == 8'h09) begin s = a + m + c; na = s[3:0]; nc = (s > 15); k = nc; w = 1; end
    else if (op[7:4] == 4'h3) begin s = a + op[3:0]; na = s[3:0]; k = (s > 15); w = 1; end
    else if (op[7:4] == 4'h2) begin na = op[3:0]; w = 1; end
    else if (op == 8'h51) k = !c;
    else if (op == 8'h52) k = (a == m);
    else if (op == 8'h53) k = (a == 0);
    else h = 0;
    return {h, w, na, nc, k};
  endfunction

  function automatic string req_of(input logic [7:0] op);
    if (op == 8'h08) return "R1";
    if (op == 8'h09) return "R2";
    if (op == 8'h3A) return "R4";
    if (op[7:4] == 4'h3) return "R3";
    if (op[7:4] == 4'h2) return "R5";
    if (op == 8'h51) return "R6";
    if (op == 8'h52) return "R7";
    if (op == 8'h53) return "R8";
    return "R9";
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%h a=%h m=%h c=%b actual=%h expected=%h", req, op_i, acc_i, mem_i, cy_i, act, exp);
    end
  endtask

  initial begin
    logic prev_skip;
    // R10 reset state with a skipping opcode present
    op_i = 8'h51; cy_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R10", {7'b0, skip_q_o}, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;

    // exhaustive sweep: every opcode, every A, M, C
    prev_skip = skip_o;
    for (int op = 0; op < 256; op++) begin
      for (int v = 0; v < 512; v++) begin
        @(negedge clk_i);
        check("R10", {7'b0, skip_q_o}, {7'b0, prev_skip});
        op_i = op[7:0]; acc_i = v[8:5]; mem_i = v[4:1]; cy_i = v[0];
        #1;
        check(req_of(op_i), {hit_o, wr_acc_o, acc_o, cy_o, skip_o},
              model(op_i, acc_i, mem_i, cy_i));
        prev_skip = model(op_i, acc_i, mem_i, cy_i) & 8'h01 ? 1'b1 : 1'b0;
      end
    end

    // hand-worked corner vectors
    for (int i = 0; i < NV; i++) begin
      @(negedge clk_i);
      {op_i, acc_i, mem_i, cy_i} = VEC[i][22:6];
      #1;
      check(req_of(op_i), {2'b0, acc_o, cy_o, skip_o}, {2'b0, VEC[i][5:0]});
    end

    // R9 neighbours of implemented opcodes stay inert
    op_i = 8'h54; acc_i = 4'h0; mem_i = 4'h0; cy_i = 1'b0;
    #1 check("R9", {hit_o, wr_acc_o, acc_o, cy_o, skip_o}, {2'b00, 4'h0, 1'b0, 1'b0});

    // R10 asynchronous reset clears registered skip mid-run
    @(negedge clk_i); op_i = 8'h53; acc_i = 4'h0;
    @(negedge clk_i);
    check("R10", {7'b0, skip_q_o}, 8'h01);
    #0.5 rst_ni = 1'b0;
    #0.5 check("R10", {7'b0, skip_q_o}, 8'h00);
    @(negedge clk_i); rst_ni = 1'b1;
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule